// File: doc/BRIEF.md
# DMA Channel Descriptor Fetch Engine

This block sits inside a multi-channel DMA controller and turns a peripheral's request into a sequence of transfer addresses. Each channel owns two control structures in system memory, a primary and an alternate. Both are located by a fixed offset from a programmable base pointer. When a channel asks for service, the engine computes where the selected structure lives and reads its three live words over a valid/ready read port. It keeps the decoded descriptor in local registers and then issues one transfer command per accepted handshake on a valid/ready transfer port. Source and destination addresses are computed backward from the stored end pointers. Once the last transfer is accepted, the engine raises that channel's bit of a done vector for one cycle.

Requests that arrive while the engine is busy are remembered. The lowest-numbered waiting channel is served next. A channel in ping-pong mode flips its primary/alternate select each time a structure completes, so its next request reads the other structure. A channel in basic mode always reuses the same structure. Back-pressure works as follows. The engine holds `rd_addr` steady until `rd_ready` accepts it. It holds every transfer field steady until `xfer_ready` accepts it. It always accepts read responses, in the order the reads were issued.

Top module: `dmadesc_engine`

## Requirements
- R1: While reset is asserted and right after it is released, `rd_valid`, `xfer_valid` and every bit of `done` are 0, and every channel's structure select points to the primary structure.
- R2: For channel n the structure address is `base_ptr + 16*n`, plus `0x100` when the alternate structure is selected. The engine reads offsets +0 (source end), +4 (destination end) and +8 (configuration) in that order and never reads +12.
- R3: While `rd_valid` is high and `rd_ready` is low, `rd_addr` holds. No transfer is offered until all three read responses have returned.
- R4: The configuration word is laid out as bits [9:0] transfer count minus one, [11:10] size code (0 byte, 1 halfword, 2 word), [13:12] source increment code, [15:14] destination increment code and [18:16] cycle mode (0 stop, 1 basic, 3 ping-pong). `xfer_size` reports the size code.
- R5: For a transfer with r transfers still to follow, each address is `end_ptr - (r << inc)`, where the increment code inc is 0, 1 or 2. Increment code 3 leaves the address equal to the end pointer.
- R6: A descriptor with count field c produces exactly c+1 accepted transfers. While `xfer_valid` is high and `xfer_ready` is low, every transfer field holds.
- R7: The cycle after the last transfer is accepted, `done` has only the serving channel's bit set, for exactly one cycle. At all other times `done` is 0.
- R8: Completing a ping-pong structure toggles that channel's select, and `xfer_alt` reports which structure is in use. Completing a basic structure leaves the select unchanged.
- R9: A cycle mode of 0 or any code other than 1 or 3 produces no transfer and no done pulse, and leaves the channel's select unchanged.
- R10: Changes to a descriptor in memory after its three words have been read do not alter the transfers of the run in progress.
- R11: Requests that arrive while a channel is being served are held. When the engine becomes free, it serves the lowest-numbered waiting channel first.
- R12: `rd_valid` and `xfer_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_ptr | input | AW | Base address of the structure table |
| chan_req | input | NCH | Per-channel service request; each high cycle registers a request |
| rd_valid | output | 1 | Descriptor read address valid |
| rd_ready | input | 1 | Memory accepts the read address |
| rd_addr | output | AW | Descriptor word address |
| rsp_valid | input | 1 | Read response valid (always accepted) |
| rsp_data | input | 32 | Read response word |
| xfer_valid | output | 1 | Transfer command valid |
| xfer_ready | input | 1 | Transfer command accepted |
| xfer_src | output | AW | Source address of this transfer |
| xfer_dst | output | AW | Destination address of this transfer |
| xfer_size | output | 2 | Data size code |
| xfer_chan | output | CHW | Channel being served |
| xfer_alt | output | 1 | 1 when the alternate structure is in use |
| done | output | NCH | One-cycle completion pulse per channel |

## Verification
The bound checker checks the following in every cycle: both handshake ports hold steady under back-pressure, `done` is at most one-hot, lasts one cycle and only follows an accepted transfer, and a fetch never overlaps a transfer. Other behaviours can only be shown by the bench's scenarios, because they depend on what memory holds and on the order of requests. These are the descriptor address arithmetic, the backward address computation for each increment code, the exact transfer count, ping-pong alternation, the stop and reserved modes, the insulation of the cached copy from memory writes, and lowest-first service of held requests.

// File: rtl/dmadesc_pkg.sv
package dmadesc_pkg;
  localparam int CNT_W = 10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2
  } eng_state_t;

  localparam logic [2:0] MODE_STOP     = 3'd0;
  localparam logic [2:0] MODE_BASIC    = 3'd1;
  localparam logic [2:0] MODE_PINGPONG = 3'd3;

  localparam logic [1:0] INC_NONE = 2'd3;

  // live part of the configuration word, bits [18:0]
  typedef struct packed {
    logic [2:0]       mode;
    logic [1:0]       dinc;
    logic [1:0]       sinc;
    logic [1:0]       size;
    logic [CNT_W-1:0] nm1;
  } desc_cfg_t;
endpackage

// File: rtl/dmadesc_pick.sv
module dmadesc_pick #(
  parameter int N = 24,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/dmadesc_addrgen.sv
module dmadesc_addrgen #(
  parameter int AW = 32,
  parameter int CW = 10
) (
  input  logic [AW-1:0] end_ptr,
  input  logic [CW-1:0] remain,
  input  logic [1:0]    inc,
  output logic [AW-1:0] addr
);
  always_comb begin
    if (inc == dmadesc_pkg::INC_NONE) addr = end_ptr;
    else                               addr = end_ptr - (AW'(remain) << inc);
  end
endmodule

// File: rtl/dmadesc_engine.sv
module dmadesc_engine #(
  parameter int          NCH          = 24,
  parameter int          AW           = 32,
  parameter logic [31:0] ALT_OFS      = 32'h100,
  parameter int          STRUCT_BYTES = 16,
  localparam int         CHW          = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  base_ptr,
  input  logic [NCH-1:0] chan_req,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [AW-1:0]  rd_addr,
  input  logic           rsp_valid,
  input  logic [31:0]    rsp_data,
  output logic           xfer_valid,
  input  logic           xfer_ready,
  output logic [AW-1:0]  xfer_src,
  output logic [AW-1:0]  xfer_dst,
  output logic [1:0]     xfer_size,
  output logic [CHW-1:0] xfer_chan,
  output logic           xfer_alt,
  output logic [NCH-1:0] done
);
  import dmadesc_pkg::*;

  localparam int         SB_SH    = $clog2(STRUCT_BYTES);
  localparam logic [1:0] LAST_WRD = 2'd2;   // configuration word index
  localparam logic [1:0] N_WORDS  = 2'd3;   // reserved word is skipped

  eng_state_t       state;
  logic [NCH-1:0]   pend;
  logic [NCH-1:0]   alt_sel;
  logic [CHW-1:0]   cur_ch;
  logic             cur_alt;
  logic [1:0]       n_issued;
  logic [1:0]       n_got;
  logic [AW-1:0]    src_end;
  logic [AW-1:0]    dst_end;
  desc_cfg_t        cfg_q;
  desc_cfg_t        rsp_cfg;
  logic [CNT_W-1:0] remain;
  logic [NCH-1:0]   done_q;

  logic             pick_any;
  logic [CHW-1:0]   pick_idx;
  logic [NCH-1:0]   pend_clr;
  logic [AW-1:0]    struct_base;
  logic             mode_runs;

  dmadesc_pick #(.N(NCH)) i_pick (
    .req (pend),
    .any (pick_any),
    .idx (pick_idx)
  );

  dmadesc_addrgen #(.AW(AW), .CW(CNT_W)) i_src_gen (
    .end_ptr (src_end),
    .remain  (remain),
    .inc     (cfg_q.sinc),
    .addr    (xfer_src)
  );

  dmadesc_addrgen #(.AW(AW), .CW(CNT_W)) i_dst_gen (
    .end_ptr (dst_end),
    .remain  (remain),
    .inc     (cfg_q.dinc),
    .addr    (xfer_dst)
  );

  assign rsp_cfg     = desc_cfg_t'(rsp_data[$bits(desc_cfg_t)-1:0]);
  assign mode_runs   = (rsp_cfg.mode == MODE_BASIC) || (rsp_cfg.mode == MODE_PINGPONG);
  assign struct_base = base_ptr + (cur_alt ? AW'(ALT_OFS) : '0) + (AW'(cur_ch) << SB_SH);
  assign pend_clr    = (state == ST_IDLE && pick_any) ? (NCH'(1) << pick_idx) : '0;

  assign rd_valid   = (state == ST_FETCH) && (n_issued != N_WORDS);
  assign rd_addr    = struct_base + AW'({n_issued, 2'b00});
  assign xfer_valid = (state == ST_RUN);
  assign xfer_size  = cfg_q.size;
  assign xfer_chan  = cur_ch;
  assign xfer_alt   = cur_alt;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pend     <= '0;
      alt_sel  <= '0;
      cur_ch   <= '0;
      cur_alt  <= 1'b0;
      n_issued <= '0;
      n_got    <= '0;
      src_end  <= '0;
      dst_end  <= '0;
      cfg_q    <= '0;
      remain   <= '0;
      done_q   <= '0;
    end else begin
      done_q <= '0;
      pend   <= (pend & ~pend_clr) | chan_req;
      unique case (state)
        ST_IDLE: begin
          if (pick_any) begin
            cur_ch   <= pick_idx;
            cur_alt  <= alt_sel[pick_idx];
            n_issued <= '0;
            n_got    <= '0;
            state    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (rd_valid && rd_ready) n_issued <= n_issued + 2'd1;
          if (rsp_valid) begin
            n_got <= n_got + 2'd1;
            case (n_got)
              2'd0:     src_end <= rsp_data;
              2'd1:     dst_end <= rsp_data;
              LAST_WRD: begin
                cfg_q  <= rsp_cfg;
                remain <= rsp_cfg.nm1;
                state  <= mode_runs ? ST_RUN : ST_IDLE;
              end
              default: ;
            endcase
          end
        end
        ST_RUN: begin
          if (xfer_ready) begin
            if (remain == '0) begin
              done_q[cur_ch] <= 1'b1;
              if (cfg_q.mode == MODE_PINGPONG) alt_sel[cur_ch] <= ~alt_sel[cur_ch];
              state <= ST_IDLE;
            end else begin
              remain <= remain - 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmadesc_engine_chk.sv
module dmadesc_engine_chk #(
  parameter int NCH = 24,
  parameter int AW  = 32,
  parameter int CHW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd_valid,
  input logic           rd_ready,
  input logic [AW-1:0]  rd_addr,
  input logic           xfer_valid,
  input logic           xfer_ready,
  input logic [AW-1:0]  xfer_src,
  input logic [AW-1:0]  xfer_dst,
  input logic [CHW-1:0] xfer_chan,
  input logic [NCH-1:0] done
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R3

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_src) && $stable(xfer_dst) && $stable(xfer_chan)); // R6

  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done != '0) |=> ((done & $past(done)) == '0)); // R7

  AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (done != '0) |-> $past(xfer_valid && xfer_ready)); // R7

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && xfer_valid)); // R12
endmodule

bind dmadesc_engine dmadesc_engine_chk #(.NCH(NCH), .AW(AW), .CHW(CHW)) i_chk (.*);

// File: tb/test_dmadesc_engine.sv
`timescale 1ns/1ps
module test_dmadesc_engine;
  localparam int          NCH     = 24;
  localparam int          CHW     = 5;
  localparam logic [31:0] MEMBASE = 32'h2000_0000;
  localparam logic [31:0] BASE    = 32'h2000_0040;

  typedef struct packed {
    logic [4:0]  ch;
    logic [2:0]  mode;
    logic [9:0]  nm1;
    logic [1:0]  size;
    logic [1:0]  sinc;
    logic [1:0]  dinc;
    logic [31:0] src;
    logic [31:0] dst;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{5'd0,  3'd1, 10'd3,  2'd2, 2'd2, 2'd3, 32'h1000_0100, 32'h4000_0020},
    '{5'd5,  3'd1, 10'd0,  2'd0, 2'd0, 2'd0, 32'h1000_0200, 32'h1000_0300},
    '{5'd23, 3'd1, 10'd7,  2'd1, 2'd1, 2'd0, 32'h1000_0040, 32'h2000_0800},
    '{5'd9,  3'd1, 10'd4,  2'd0, 2'd3, 2'd2, 32'h4000_0010, 32'h1000_0ABC},
    '{5'd12, 3'd1, 10'd20, 2'd2, 2'd1, 2'd2, 32'h1000_0400, 32'h1000_0900}
  };

  typedef struct packed {
    logic [4:0]  ch;
    logic        alt;
    logic [1:0]  size;
    logic [31:0] src;
    logic [31:0] dst;
  } xrec_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n;
  logic [31:0]    base_ptr;
  logic [NCH-1:0] chan_req;
  logic           rd_valid, rd_ready, rsp_valid;
  logic [31:0]    rd_addr, rsp_data;
  logic           xfer_valid, xfer_ready, xfer_alt;
  logic [31:0]    xfer_src, xfer_dst;
  logic [1:0]     xfer_size;
  logic [CHW-1:0] xfer_chan;
  logic [NCH-1:0] done;

  dmadesc_engine i_dmadesc_engine (
    .clk(clk), .rst_n(rst_n), .base_ptr(base_ptr), .chan_req(chan_req),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_src(xfer_src),
    .xfer_dst(xfer_dst), .xfer_size(xfer_size), .xfer_chan(xfer_chan),
    .xfer_alt(xfer_alt), .done(done)
  );

  int errs = 0, checks = 0;
  bit finished = 0;
  logic [31:0] mem [0:255];
  logic [31:0] rdq[$], rd_log[$];
  xrec_t       xlog[$];
  logic [NCH-1:0] done_log[$];
  int          done_at[$];
  int          samp = 0, last_x = 0, rsp_seen = 0, rsp_at_x0 = -1, overlap = 0;
  bit          stall_en = 0, hold_x = 0;
  logic [7:0]  lf = 8'h5a;

  function automatic int midx(input logic [31:0] a);
    return int'(((a - MEMBASE) >> 2) & 32'hff);
  endfunction

  function automatic logic [31:0] mkcfg(input logic [2:0] mode, input logic [9:0] nm1,
      input logic [1:0] size, input logic [1:0] sinc, input logic [1:0] dinc);
    return {13'd0, mode, dinc, sinc, size, nm1};
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] e, input int r, input logic [1:0] inc);
    return (inc == 2'd3) ? e : e - (32'(r) << inc);
  endfunction

  function automatic logic [31:0] sbase(input int ch, input bit alt);
    return BASE + (alt ? 32'h100 : 32'h0) + 32'(16 * ch);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: sample away from the active edge
  always @(negedge clk) begin
    samp++;
    if (rst_n) begin
      if (rd_valid && rd_ready) begin rdq.push_back(rd_addr); rd_log.push_back(rd_addr); end
      if (xfer_valid && xfer_ready) begin
        xrec_t r;
        if (xlog.size() == 0) rsp_at_x0 = rsp_seen;
        r.ch = xfer_chan; r.alt = xfer_alt; r.size = xfer_size; r.src = xfer_src; r.dst = xfer_dst;
        xlog.push_back(r);
        last_x = samp;
      end
      if (done != '0) begin done_log.push_back(done); done_at.push_back(samp); end
      if (rd_valid && xfer_valid) overlap++;
    end
  end

  // memory and sink model, driven just after each rising edge
  always begin
    @(posedge clk); #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    rd_ready   = stall_en ? (lf[0] | lf[2]) : 1'b1;
    xfer_ready = hold_x ? 1'b0 : (stall_en ? (lf[1] | lf[4]) : 1'b1);
    if (rdq.size() > 0 && !(stall_en && lf[6])) begin
      logic [31:0] a;
      a = rdq.pop_front();
      rsp_valid = 1'b1;
      rsp_data  = mem[midx(a)];
      rsp_seen++;
    end else begin
      rsp_valid = 1'b0;
      rsp_data  = '0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(posedge clk); #1; chan_req = m;
    @(posedge clk); #1; chan_req = '0;
  endtask

  task automatic wait_dones(input int n);
    for (int t = 0; t < 5000 && done_log.size() < n; t++) @(posedge clk);
    tick(3);
  endtask

  task automatic clear_logs();
    rd_log.delete(); xlog.delete(); done_log.delete(); done_at.delete();
    rsp_seen = 0; rsp_at_x0 = -1;
  endtask

  task automatic set_desc(input int ch, input bit alt, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] c);
    int i;
    i = midx(sbase(ch, alt));
    mem[i] = s; mem[i+1] = d; mem[i+2] = c; mem[i+3] = 32'hFFFF_FFFF;
  endtask

  task automatic check_run(input string what, input int ch, input bit alt,
                           input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    logic [31:0] a0, es, ed;
    int n, bad;
    bit altok;
    logic [NCH-1:0] oh;
    a0 = sbase(ch, alt);
    n  = int'(c[9:0]) + 1;
    chk(rd_log.size() == 3 && rd_log[0] == a0 && rd_log[1] == a0 + 4 && rd_log[2] == a0 + 8,
        "R2", {what, " structure read order"}, (rd_log.size() > 0) ? rd_log[0] : 0, a0);
    chk(rsp_at_x0 == 3, "R3", {what, " responses before first transfer"}, rsp_at_x0, 3);
    chk(xlog.size() == n, "R6", {what, " transfer count"}, xlog.size(), n);
    bad = -1; altok = 1; es = 0; ed = 0;
    for (int k = 0; k < xlog.size() && k < n; k++) begin
      es = exp_addr(s, n - 1 - k, c[13:12]);
      ed = exp_addr(d, n - 1 - k, c[15:14]);
      if (xlog[k].alt != alt) altok = 0;
      if (bad < 0 && (xlog[k].src != es || xlog[k].dst != ed || xlog[k].ch != ch[4:0]
                      || xlog[k].size != c[11:10])) bad = k;
    end
    chk(bad < 0, "R5", {what, " addresses (R4 size field)"},
        (bad >= 0) ? {xlog[bad].src, xlog[bad].dst} : 64'd0,
        (bad >= 0) ? {exp_addr(s, n - 1 - bad, c[13:12]), exp_addr(d, n - 1 - bad, c[15:14])} : 64'd0);
    chk(altok, "R8", {what, " structure select reported"}, !alt, alt);
    oh = NCH'(1) << ch;
    chk(done_log.size() == 1 && done_log[0] == oh && done_at[0] == last_x + 1, "R7",
        {what, " done pulse"}, (done_log.size() > 0) ? done_log[0] : 0, oh);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [31:0] c;
    rst_n = 0; chan_req = '0; base_ptr = BASE;
    rd_ready = 1; xfer_ready = 1; rsp_valid = 0; rsp_data = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    tick(4);
    chk(!rd_valid && !xfer_valid && done == '0, "R1", "outputs in reset", {rd_valid, xfer_valid}, 0);
    rst_n = 1;
    tick(2);
    chk(!rd_valid && !xfer_valid && done == '0, "R1", "outputs after reset", {rd_valid, xfer_valid}, 0);

    // table of basic-mode runs, alternating back-pressure
    for (int i = 0; i < 5; i++) begin
      vec_t v;
      v = VEC[i];
      c = mkcfg(v.mode, v.nm1, v.size, v.sinc, v.dinc);
      stall_en = i[0];
      clear_logs();
      set_desc(v.ch, 0, v.src, v.dst, c);
      pulse(NCH'(1) << v.ch);
      wait_dones(1);
      check_run($sformatf("vec%0d", i), v.ch, 0, v.src, v.dst, c);
    end
    stall_en = 0;

    // R8: basic mode keeps the primary structure on a repeat
    c = mkcfg(3'd1, VEC[0].nm1, VEC[0].size, VEC[0].sinc, VEC[0].dinc);
    clear_logs(); pulse(NCH'(1)); wait_dones(1);
    check_run("basic repeat", 0, 0, VEC[0].src, VEC[0].dst, c);

    // R8: ping-pong alternates primary, alternate, primary
    set_desc(2, 0, 32'h1000_1000, 32'h1000_2000, mkcfg(3'd3, 10'd1, 2'd2, 2'd2, 2'd2));
    set_desc(2, 1, 32'h1000_3000, 32'h1000_4000, mkcfg(3'd3, 10'd2, 2'd0, 2'd0, 2'd3));
    clear_logs(); pulse(NCH'(1) << 2); wait_dones(1);
    check_run("pingpong primary", 2, 0, 32'h1000_1000, 32'h1000_2000, mkcfg(3'd3, 10'd1, 2'd2, 2'd2, 2'd2));
    clear_logs(); pulse(NCH'(1) << 2); wait_dones(1);
    check_run("pingpong alternate", 2, 1, 32'h1000_3000, 32'h1000_4000, mkcfg(3'd3, 10'd2, 2'd0, 2'd0, 2'd3));
    clear_logs(); pulse(NCH'(1) << 2); wait_dones(1);
    check_run("pingpong back", 2, 0, 32'h1000_1000, 32'h1000_2000, mkcfg(3'd3, 10'd1, 2'd2, 2'd2, 2'd2));

    // R9: stop and reserved modes do nothing, select untouched
    set_desc(4, 0, 32'h1000_5000, 32'h1000_6000, mkcfg(3'd0, 10'd3, 2'd2, 2'd2, 2'd2));
    clear_logs(); pulse(NCH'(1) << 4); tick(40);
    chk(xlog.size() == 0 && done_log.size() == 0, "R9", "stop mode activity", xlog.size(), 0);
    set_desc(4, 0, 32'h1000_5000, 32'h1000_6000, mkcfg(3'd5, 10'd3, 2'd2, 2'd2, 2'd2));
    clear_logs(); pulse(NCH'(1) << 4); tick(40);
    chk(xlog.size() == 0 && done_log.size() == 0, "R9", "reserved mode activity", xlog.size(), 0);
    c = mkcfg(3'd1, 10'd1, 2'd1, 2'd1, 2'd1);
    set_desc(4, 0, 32'h1000_5000, 32'h1000_6000, c);
    clear_logs(); pulse(NCH'(1) << 4); wait_dones(1);
    check_run("after stop (R9 select kept)", 4, 0, 32'h1000_5000, 32'h1000_6000, c);

    // R10: memory rewritten after fetch does not leak into the run
    c = mkcfg(3'd1, 10'd5, 2'd2, 2'd2, 2'd2);
    set_desc(6, 0, 32'h1000_7000, 32'h1000_8000, c);
    clear_logs(); hold_x = 1; pulse(NCH'(1) << 6);
    for (int t = 0; t < 2000 && !xfer_valid; t++) @(negedge clk);
    set_desc(6, 0, 32'h1555_0000, 32'h1666_0000, mkcfg(3'd1, 10'd1, 2'd0, 2'd0, 2'd0));
    tick(3); hold_x = 0;
    wait_dones(1);
    chk(xlog.size() > 0 && xlog[0].src == 32'h1000_7000 - 20, "R10", "cached source end",
        (xlog.size() > 0) ? xlog[0].src : 0, 32'h1000_7000 - 20);
    check_run("cached run", 6, 0, 32'h1000_7000, 32'h1000_8000, c);

    // R11: held requests served lowest channel first
    c = mkcfg(3'd1, 10'd2, 2'd2, 2'd2, 2'd2);
    set_desc(1, 0, 32'h1000_9000, 32'h1000_A000, c);
    set_desc(3, 0, 32'h1000_9100, 32'h1000_A100, c);
    set_desc(7, 0, 32'h1000_9200, 32'h1000_A200, c);
    set_desc(10, 0, 32'h1000_9300, 32'h1000_A300, c);
    clear_logs();
    pulse((NCH'(1) << 10) | (NCH'(1) << 7) | (NCH'(1) << 3));
    for (int t = 0; t < 2000 && !(xfer_valid && xfer_chan == 5'd3); t++) @(negedge clk);
    pulse(NCH'(1) << 1);
    wait_dones(4);
    chk(done_log.size() == 4 && done_log[0] == (NCH'(1) << 3) && done_log[1] == (NCH'(1) << 1)
        && done_log[2] == (NCH'(1) << 7) && done_log[3] == (NCH'(1) << 10),
        "R11", "service order 3,1,7,10", (done_log.size() > 1) ? done_log[1] : 0, NCH'(1) << 1);
    chk(xlog.size() == 12, "R11", "held requests all served", xlog.size(), 12);

    chk(overlap == 0, "R12", "fetch and transfer overlap", overlap, 0);
    summary();
  end
endmodule